// File: doc/BRIEF.md
# Input Capture Channel with Overrun-Tracking Flag

This block is the input-capture half of one capture/compare unit. An external pin is synchronized and watched for edges chosen by a two-bit edge mode. On every accepted edge, the value of an external free-running counter is stored in a capture register. A capture flag records that an event is waiting for software. The flag has a hidden third state: it enters this state when a further event arrives before software has acknowledged the first one. Software then needs two acknowledges to clear it. After one acknowledge, software still reads the flag as set, and that tells it an overrun occurred.

Software reaches the block through a byte-wide register port at four addresses: mode (edge select and interrupt masks), flags, capture low byte and capture high byte. A read of the low byte freezes a copy of the high byte, so the two reads always form one sample. A lock mode accepts a single capture and then holds off further edges until the mode register is written again. A test bit forces the capture register to all ones. The block also takes counter-overflow and compare-equal strobes. Each strobe sets its own flag. The three flags, masked, drive one combined interrupt. The compare strobe also leaves on a direct, unmasked interrupt line. When the channel is put in standby (`active` low), every event is ignored and all register contents are kept.

Top module: `capcom_capture`

## Requirements
- R1: Mode register (address 0) bits [1:0] select the edges: 0 ignores the pin, 1 accepts rising edges, 2 accepts falling edges, 3 accepts both.
- R2: A pin change that is stable before clock edge k is captured at edge k+2. The capture register (address 2 low byte, address 3 high byte) takes the counter value sampled at that edge, and flag bit 1 (address 1) reads 1 after that edge.
- R3: The capture register holds the value of the most recent accepted edge.
- R4: Writing 1 to flag bit 1 is an acknowledge. An event that arrives while bit 1 is set moves the flag to an overrun state. From the overrun state the first acknowledge leaves bit 1 reading 1 and the second acknowledge clears it.
- R5: When an accepted edge and an acknowledge of bit 1 fall on the same clock, the edge wins. A clear flag becomes set, and a set flag becomes overrun.
- R6: While flag-register bit 3 (lock enable) is 1, the first accepted edge locks the channel. Later edges change neither the capture register nor the flag until any write to address 0 unlocks it.
- R7: A read strobe at address 2 freezes a copy of the high byte. Address 3 returns that copy until a read strobe at address 3 releases it, whatever captures happen between the two reads.
- R8: While flag-register bit 4 is 1, the capture register is forced to FFFFh. After the bit is cleared, the register keeps FFFFh until the next accepted edge.
- R9: Flag bit 0 is set by `ovf_evt` and flag bit 2 by `cmp_evt`. A write of 1 to a flag bit clears it, and a write of 0 leaves it unchanged.
- R10: `irq_comb` is the OR of the three flags, each ANDed with its mask bit in the mode register: bit 2 masks overflow, bit 3 masks capture, bit 4 masks compare. It follows the flags in the same cycle.
- R11: `irq_cmp` is high in the cycle after a clock edge that sampled `cmp_evt` high, and it ignores the masks.
- R12: While `active` is low, pin edges and both strobes are ignored, and the flags, masks and capture register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, the only clear for flags and masks |
| active | input | 1 | Channel enable; low puts the channel in standby |
| cap_pin | input | 1 | Asynchronous external capture input |
| cnt_value | input | 2*BYTE_W | Free-running counter value |
| ovf_evt | input | 1 | Counter overflow strobe |
| cmp_evt | input | 1 | Compare-equal strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 flags, 2 capture low, 3 capture high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | BYTE_W | Register write data |
| reg_rd | input | 1 | Register read strobe (side effects at addresses 2 and 3) |
| reg_rdata | output | BYTE_W | Register read data, combinational from the address |
| irq_comb | output | 1 | Masked OR of the three flags |
| irq_cmp | output | 1 | Direct compare interrupt, one cycle after the strobe |

## Verification
Each result has a known latency. A pin change becomes visible in the capture register and flag two edges after the first edge that samples it. Flag and mask writes take effect at the edge that samples them, and `irq_comb` follows within the same cycle. `irq_cmp` rises one edge after the strobe. The bench drives inputs 5 ns after a rising edge and compares every output with a cycle-based reference model at the falling edge, so each value is checked in the cycle it is due. Directed checks place an edge and an acknowledge on the same clock, fit a capture between the low and high reads, and count acknowledges out of the overrun state.

// File: rtl/capcom_pkg.sv
package capcom_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    CAPF_IDLE = 2'd0,
    CAPF_SET  = 2'd1,
    CAPF_OVER = 2'd2
  } capf_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_CAPL = 2'd2;
  localparam logic [1:0] A_CAPH = 2'd3;

  localparam int B_OVF = 0;
  localparam int B_CAP = 1;
  localparam int B_CMP = 2;
  localparam int B_LAC = 3;
  localparam int B_FRC = 4;

  localparam int M_MSK_LO = 2;
  localparam int M_MSK_HI = 4;

  function automatic logic edge_match(edge_sel_e sel, logic now_v, logic before_v);
    case (sel)
      EDGE_RISE: return now_v & ~before_v;
      EDGE_FALL: return ~now_v & before_v;
      EDGE_ANY:  return now_v ^ before_v;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic capf_e capf_step(capf_e cur, logic evt, logic ack);
    if (evt) return (cur == CAPF_IDLE) ? CAPF_SET : CAPF_OVER;
    if (ack) begin
      case (cur)
        CAPF_OVER: return CAPF_SET;
        default:   return CAPF_IDLE;
      endcase
    end
    return cur;
  endfunction

endpackage

// File: rtl/capcom_insync.sv
module capcom_insync
  import capcom_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_async,
  input  edge_sel_e sel,
  output logic      edge_seen
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign edge_seen = edge_match(sel, chain[STAGES-1], last_q);
endmodule

// File: rtl/capcom_capflag.sv
module capcom_capflag
  import capcom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt,
  input  logic  ack,
  output capf_e state,
  output logic  pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CAPF_IDLE;
    else        state <= capf_step(state, evt, ack);
  end

  assign pending = (state != CAPF_IDLE);
endmodule

// File: rtl/capcom_capreg.sv
module capcom_capreg #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                force_ones,
  input  logic [2*BYTE_W-1:0] sample,
  input  logic                rd_low,
  input  logic                rd_high,
  output logic [2*BYTE_W-1:0] value,
  output logic [BYTE_W-1:0]   low_view,
  output logic [BYTE_W-1:0]   high_view
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] snap_q;
  logic              frozen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          value <= '0;
    else if (force_ones) value <= '1;
    else if (load)       value <= sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      frozen_q <= 1'b0;
    end else if (rd_low) begin
      snap_q   <= value[WORD_W-1:BYTE_W];
      frozen_q <= 1'b1;
    end else if (rd_high) begin
      frozen_q <= 1'b0;
    end
  end

  assign low_view  = value[BYTE_W-1:0];
  assign high_view = frozen_q ? snap_q : value[WORD_W-1:BYTE_W];
endmodule

// File: rtl/capcom_capture.sv
module capcom_capture
  import capcom_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                cap_pin,
  input  logic [2*BYTE_W-1:0] cnt_value,
  input  logic                ovf_evt,
  input  logic                cmp_evt,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic                reg_rd,
  output logic [BYTE_W-1:0]   reg_rdata,
  output logic                irq_comb,
  output logic                irq_cmp
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NMASK  = M_MSK_HI - M_MSK_LO + 1;

  edge_sel_e         edge_mode;
  logic [NMASK-1:0]  mask_q;
  logic              lac_q, force_q, locked_q;
  logic              ovf_q, cmp_q, irq_cmp_q;

  logic              wr_mode, wr_flag;
  logic              ack_ovf, ack_cap, ack_cmp;
  logic              edge_seen, trig, ovf_hit, cmp_hit;
  logic              cap_pending, rd_low, rd_high;
  capf_e             cap_state;
  logic [WORD_W-1:0] cap_val;
  logic [BYTE_W-1:0] low_view, high_view;
  logic [NMASK-1:0]  flag_vec;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign ack_ovf = wr_flag && reg_wdata[B_OVF];
  assign ack_cap = wr_flag && reg_wdata[B_CAP];
  assign ack_cmp = wr_flag && reg_wdata[B_CMP];
  assign rd_low  = reg_rd && (reg_addr == A_CAPL);
  assign rd_high = reg_rd && (reg_addr == A_CAPH);

  assign trig    = active && !locked_q && edge_seen;
  assign ovf_hit = active && ovf_evt;
  assign cmp_hit = active && cmp_evt;

  capcom_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (cap_pin),
    .sel       (edge_mode),
    .edge_seen (edge_seen)
  );

  capcom_capflag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (trig),
    .ack     (ack_cap),
    .state   (cap_state),
    .pending (cap_pending)
  );

  capcom_capreg #(.BYTE_W(BYTE_W)) u_creg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (trig),
    .force_ones (force_q),
    .sample     (cnt_value),
    .rd_low     (rd_low),
    .rd_high    (rd_high),
    .value      (cap_val),
    .low_view   (low_view),
    .high_view  (high_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_mode <= EDGE_NONE;
      mask_q    <= '0;
    end else if (wr_mode) begin
      edge_mode <= edge_sel_e'(reg_wdata[1:0]);
      mask_q    <= reg_wdata[M_MSK_HI:M_MSK_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lac_q   <= 1'b0;
      force_q <= 1'b0;
    end else if (wr_flag) begin
      lac_q   <= reg_wdata[B_LAC];
      force_q <= reg_wdata[B_FRC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              locked_q <= 1'b0;
    else if (wr_mode)        locked_q <= 1'b0;
    else if (trig && lac_q)  locked_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q     <= 1'b0;
      cmp_q     <= 1'b0;
      irq_cmp_q <= 1'b0;
    end else begin
      if (ovf_hit)      ovf_q <= 1'b1;
      else if (ack_ovf) ovf_q <= 1'b0;
      if (cmp_hit)      cmp_q <= 1'b1;
      else if (ack_cmp) cmp_q <= 1'b0;
      irq_cmp_q <= cmp_hit;
    end
  end

  assign flag_vec = {cmp_q, cap_pending, ovf_q};
  assign irq_comb = |(flag_vec & mask_q);
  assign irq_cmp  = irq_cmp_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[1:0]               = edge_mode;
        reg_rdata[M_MSK_HI:M_MSK_LO] = mask_q;
      end
      A_FLAG: begin
        reg_rdata[B_OVF] = ovf_q;
        reg_rdata[B_CAP] = cap_pending;
        reg_rdata[B_CMP] = cmp_q;
        reg_rdata[B_LAC] = lac_q;
        reg_rdata[B_FRC] = force_q;
      end
      A_CAPL:  reg_rdata = low_view;
      default: reg_rdata = high_view;
    endcase
  end
endmodule

// File: rtl/capcom_capture_chk.sv
module capcom_capture_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              trig,
  input logic              edge_seen,
  input logic              locked,
  input logic [1:0]        edge_mode,
  input logic              force_on,
  input logic [WORD_W-1:0] cap_val,
  input logic [WORD_W-1:0] cnt_value,
  input logic [1:0]        cap_state,
  input logic              cmp_evt,
  input logic              irq_cmp
);
  p_off_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'd0) |-> !edge_seen);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !force_on) |=> (cap_val == $past(cnt_value)));

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cap_state != 2'd0) |=> (cap_state == 2'd2));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cap_state != 2'd0));

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !trig);

  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> (cap_val == {WORD_W{1'b1}}));

  p_direct_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp_evt) |=> irq_cmp);

  p_standby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!trig && !$rose(irq_cmp)));
endmodule

bind capcom_capture capcom_capture_chk #(.WORD_W(2*BYTE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .trig      (trig),
  .edge_seen (edge_seen),
  .locked    (locked_q),
  .edge_mode (edge_mode),
  .force_on  (force_q),
  .cap_val   (cap_val),
  .cnt_value (cnt_value),
  .cap_state (cap_state),
  .cmp_evt   (cmp_evt),
  .irq_cmp   (irq_cmp)
);

// File: tb/test_capcom_capture.sv
module test_capcom_capture;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        active = 1;
  logic        cap_pin = 0;
  logic [15:0] cnt_value = 16'h1200;
  logic        ovf_evt = 0, cmp_evt = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        irq_comb, irq_cmp;

  int total = 0, bad = 0;
  bit done = 0;

  capcom_capture i_capcom_capture (
    .clk(clk), .rst_n(rst_n), .active(active), .cap_pin(cap_pin),
    .cnt_value(cnt_value), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_comb(irq_comb), .irq_cmp(irq_cmp)
  );

  always #10 clk = ~clk;
  always @(posedge clk) begin #2; cnt_value = cnt_value + 16'd1; end

  // reference model, advanced once per rising edge
  int m_edge, m_mask, m_lac, m_frc, m_lock, m_ovf, m_cmp, m_flag, m_cap;
  int m_frz, m_snap, m_irqcmp, m_trig, m_wm, m_wf, m_old;
  int hist[$];

  function automatic int accepts(int sel, int now_v, int before_v);
    if (now_v == before_v) return 0;
    if (sel == 3) return 1;
    if (sel == 1) return now_v;
    if (sel == 2) return before_v;
    return 0;
  endfunction

  function automatic int exp_rd(int a);
    if (a == 0) return m_edge + 4 * m_mask;
    if (a == 1) return m_ovf + 2 * (m_flag > 0 ? 1 : 0) + 4 * m_cmp + 8 * m_lac + 16 * m_frc;
    if (a == 2) return m_cap % 256;
    return m_frz ? m_snap : m_cap / 256;
  endfunction

  function automatic int exp_irq();
    return ((m_mask & 1) != 0 && m_ovf != 0) || ((m_mask & 2) != 0 && m_flag != 0) ||
           ((m_mask & 4) != 0 && m_cmp != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_mask = 0; m_lac = 0; m_frc = 0; m_lock = 0; m_ovf = 0; m_cmp = 0;
      m_flag = 0; m_cap = 0; m_frz = 0; m_snap = 0; m_irqcmp = 0;
      hist = '{0, 0, 0};
    end else begin
      m_wm = (reg_wr && reg_addr == 0) ? 1 : 0;
      m_wf = (reg_wr && reg_addr == 1) ? 1 : 0;
      m_trig = (active && m_lock == 0) ? accepts(m_edge, hist[1], hist[2]) : 0;
      m_old = m_cap;
      if (m_trig != 0) m_flag = (m_flag == 0) ? 1 : 2;
      else if (m_wf != 0 && reg_wdata[1]) m_flag = (m_flag == 2) ? 1 : 0;
      if (m_frc != 0) m_cap = 65535;
      else if (m_trig != 0) m_cap = int'(cnt_value);
      if (m_wm != 0) m_lock = 0;
      else if (m_trig != 0 && m_lac != 0) m_lock = 1;
      if (active && ovf_evt) m_ovf = 1; else if (m_wf != 0 && reg_wdata[0]) m_ovf = 0;
      if (active && cmp_evt) m_cmp = 1; else if (m_wf != 0 && reg_wdata[2]) m_cmp = 0;
      m_irqcmp = (active && cmp_evt) ? 1 : 0;
      if (reg_rd && reg_addr == 2) begin m_frz = 1; m_snap = m_old / 256; end
      else if (reg_rd && reg_addr == 3) m_frz = 0;
      if (m_wm != 0) begin m_edge = reg_wdata % 4; m_mask = (reg_wdata / 4) % 8; end
      if (m_wf != 0) begin m_lac = reg_wdata[3]; m_frc = reg_wdata[4]; end
      hist.push_front(int'(cap_pin));
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq_comb vs model", int'(irq_comb), exp_irq());
      check("R11 irq_cmp vs model", int'(irq_cmp), m_irqcmp);
      case (reg_addr)
        2'd0:    check("R1 mode readback vs model", int'(reg_rdata), exp_rd(0));
        2'd1:    check("R4 flag readback vs model", int'(reg_rdata), exp_rd(1));
        default: check("R7 capture readback vs model", int'(reg_rdata), exp_rd(int'(reg_addr)));
      endcase
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #5; reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(posedge clk); #5; reg_wr = 0;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    @(posedge clk); #5; reg_addr = 2'(a);
    @(negedge clk); check(tag, int'(reg_rdata), exp);
  endtask

  task automatic rd_byte(input int a, input int exp, input string tag);
    @(posedge clk); #5; reg_addr = 2'(a); reg_rd = 1;
    @(negedge clk); check(tag, int'(reg_rdata), exp);
    @(posedge clk); #5; reg_rd = 0;
  endtask

  task automatic set_pin(input logic v, output int c);
    @(posedge clk); #5; cap_pin = v; c = int'(cnt_value);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic peek_cap(input int v, input string tag);
    peek(2, v % 256, tag);
    peek(3, (v / 256) % 256, tag);
  endtask

  task automatic pulse_ovf();
    @(posedge clk); #5; ovf_evt = 1;
    @(posedge clk); #5; ovf_evt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, c2, v;
    repeat (5) @(posedge clk);
    #5; rst_n = 1;
    // reset state
    peek(0, 0, "R1 reset mode");
    peek(1, 0, "R9 reset flags");
    peek_cap(0, "R2 reset capture");
    // R1 ignore mode
    wr(0, 8'h00);
    set_pin(1, c); idle(4); set_pin(0, c); idle(4);
    peek(1, 0, "R1 mode 0 ignores edges");
    // R1 rising, R2 latency and value
    wr(0, 8'h01);
    set_pin(1, c); idle(4);
    peek_cap(c + 2, "R2 captured counter value");
    peek(1, 8'h02, "R1 rising edge sets flag");
    set_pin(0, c2); idle(4);
    peek_cap(c + 2, "R1 falling ignored in rise mode");
    wr(1, 8'h02);
    peek(1, 0, "R4 single ack clears");
    // R1 falling
    wr(0, 8'h02);
    set_pin(1, c2); idle(4);
    peek(1, 0, "R1 rising ignored in fall mode");
    set_pin(0, c); idle(4);
    peek_cap(c + 2, "R1 falling captured");
    wr(1, 8'h02);
    // R1 both, R3 latest, R4 overrun
    wr(0, 8'h03);
    set_pin(1, c); idle(4);
    peek_cap(c + 2, "R1 both mode rising");
    set_pin(0, c); idle(4);
    peek_cap(c + 2, "R3 latest event kept");
    wr(1, 8'h02);
    peek(1, 8'h02, "R4 overrun survives first ack");
    wr(1, 8'h02);
    peek(1, 0, "R4 second ack clears");
    // R5 event and ack on the same edge
    set_pin(1, c); @(posedge clk); wr(1, 8'h02); idle(3);
    peek(1, 8'h02, "R5 event beats ack from clear");
    set_pin(0, c); @(posedge clk); wr(1, 8'h02); idle(3);
    wr(1, 8'h02);
    peek(1, 8'h02, "R5 event beats ack reaches overrun");
    wr(1, 8'h02);
    peek(1, 0, "R5 cleared after two acks");
    // R6 lock after capture
    wr(1, 8'h08);
    set_pin(1, c); idle(4);
    peek_cap(c + 2, "R6 first capture accepted");
    set_pin(0, c2); idle(4);
    peek_cap(c + 2, "R6 locked edge ignored");
    wr(1, 8'h0A);
    peek(1, 8'h08, "R6 no overrun while locked");
    wr(0, 8'h03);
    set_pin(1, c); idle(4);
    peek_cap(c + 2, "R6 mode write unlocks");
    wr(1, 8'h0A); wr(1, 8'h00); wr(0, 8'h03);
    // R7 coherent two-byte read
    set_pin(0, c); idle(4);
    v = c + 2;
    rd_byte(2, v % 256, "R7 low byte");
    @(posedge clk); #5; cnt_value = cnt_value + 16'h0500;
    set_pin(1, c2); idle(4);
    rd_byte(3, (v / 256) % 256, "R7 frozen high byte");
    rd_byte(2, (c2 + 2) % 256, "R7 new low byte");
    rd_byte(3, ((c2 + 2) / 256) % 256, "R7 new high byte");
    wr(1, 8'h02); wr(1, 8'h02);
    // R8 force to all ones
    wr(1, 8'h10); idle(2);
    peek_cap(16'hFFFF, "R8 forced capture");
    wr(1, 8'h00); idle(2);
    peek_cap(16'hFFFF, "R8 value held after release");
    set_pin(0, c); idle(4);
    peek_cap(c + 2, "R8 capture resumes");
    wr(1, 8'h02);
    // R9 overflow and compare flags
    pulse_ovf();
    peek(1, 8'h01, "R9 overflow flag set");
    wr(1, 8'h00);
    peek(1, 8'h01, "R9 write zero no effect");
    wr(1, 8'h01);
    peek(1, 0, "R9 overflow cleared");
    @(posedge clk); #5; cmp_evt = 1;
    @(posedge clk); #5; cmp_evt = 0;
    peek(1, 8'h04, "R9 compare flag set");
    wr(1, 8'h04);
    peek(1, 0, "R9 compare cleared");
    // R10 masking
    wr(0, 8'h04); pulse_ovf();
    @(negedge clk); check("R10 masked overflow raises irq", int'(irq_comb), 1);
    wr(0, 8'h00);
    @(negedge clk); check("R10 mask off drops irq", int'(irq_comb), 0);
    wr(1, 8'h01);
    wr(0, 8'h0B);
    set_pin(1, c); idle(4);
    @(negedge clk); check("R10 capture mask raises irq", int'(irq_comb), 1);
    wr(1, 8'h02);
    @(negedge clk); check("R10 ack drops irq", int'(irq_comb), 0);
    // R11 direct compare interrupt
    wr(0, 8'h00);
    @(posedge clk); #5; cmp_evt = 1;
    @(negedge clk); check("R11 not yet high", int'(irq_cmp), 0);
    @(posedge clk); #5; cmp_evt = 0;
    @(negedge clk); check("R11 high one cycle later unmasked", int'(irq_cmp), 1);
    @(negedge clk); check("R11 back low", int'(irq_cmp), 0);
    wr(1, 8'h04);
    // R12 standby
    wr(0, 8'h03);
    @(posedge clk); #5; active = 0;
    set_pin(0, c2); idle(4);
    pulse_ovf();
    @(posedge clk); #5; cmp_evt = 1;
    @(posedge clk); #5; cmp_evt = 0;
    idle(2);
    peek(1, 0, "R12 standby ignores events");
    peek_cap(c + 2, "R12 standby keeps capture");
    peek(0, 8'h03, "R12 standby keeps mode");
    @(posedge clk); #5; active = 1;
    idle(4);
    peek(1, 0, "R12 no late edge after wake");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule